// File: doc/BRIEF.md
# Fixed-Length Burst Read Responder

This block is the responding side of a simple request/response bus. A master starts a read by raising a request strobe for one clock cycle and putting a start address on the request address bus in that cycle. The responder waits a fixed number of cycles, then returns a burst of a fixed byte count as a stream of words. A sync flag marks each cycle that carries a word. One cycle after the last word it raises a done pulse and echoes the address of the request it has just finished.

The returned words come from an address-seeded counting pattern rather than from real storage. Word k of a burst is the start address plus k times the word size in bytes, so a master or a bench can predict every word and check the order. Requests that arrive while a burst is in flight are dropped. Requests whose address is not word aligned are served anyway. Each of these two events sets its own sticky error flag, and only reset clears the flags.

The block fits where a placeholder memory or pattern source is needed behind a master that follows this handshake, for example to bring up a read path before the real memory controller is there.

Top module: `burst_responder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every output is zero. A request strobe in that first cycle is accepted.
- R2: After a request strobe in cycle c, `rsp_sync` stays low in cycles c+1 to c+LATENCY-1. The first word appears in cycle c+LATENCY. LATENCY is a parameter from 1 to 15.
- R3: Each accepted request returns exactly BURST_BYTES/(DATA_W/8) words, in consecutive cycles, with `rsp_sync` high in each of them.
- R4: Word k (counting from 0) equals the request address plus k·(DATA_W/8), modulo 2^DATA_W. `rsp_data` is zero in every cycle where `rsp_sync` is low.
- R5: `rsp_ready` is high for exactly one cycle. That cycle comes directly after the last word, and `rsp_sync` is low in it.
- R6: `rsp_addr` carries the address of the finished request in the `rsp_ready` cycle and is zero in every other cycle.
- R7: A request strobe during a burst is ignored: the latency wait, the word cycles and the `rsp_ready` cycle all count as busy. The running burst goes on unchanged, and `err_overlap` is high from the next cycle on.
- R8: A request whose address has a nonzero value in its low log2(DATA_W/8) bits (bits 1:0 for 32-bit data) is served normally. `err_misalign` is high from the next cycle on.
- R9: A new request is accepted in the cycle right after the `rsp_ready` cycle.
- R10: Once set, `err_overlap` and `err_misalign` stay high through later bursts until `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle request strobe from the master |
| req_addr | input | ADDR_W | Start address, sampled with `req_valid` |
| rsp_sync | output | 1 | High in every cycle that carries a burst word |
| rsp_data | output | DATA_W | Burst word, zero when `rsp_sync` is low |
| rsp_ready | output | 1 | One-cycle completion pulse after the last word |
| rsp_addr | output | ADDR_W | Echoed request address during `rsp_ready`, else zero |
| err_overlap | output | 1 | Sticky: a request arrived while busy |
| err_misalign | output | 1 | Sticky: an accepted request was not word aligned |

## Verification
The bench uses an 8-word burst with a latency of 3. It sweeps many aligned start addresses, including one whose data counter wraps past the top of the address space, and checks the timing and content of each cycle against an arithmetic model. Runs of back-to-back requests, strobed in the idle cycle straight after each done pulse, test that no dead cycle is needed between bursts. A sweep of misaligned addresses tests that such requests are still served. Stray strobes placed in the wait phase, in the word phase and in the done cycle show that the running burst is left alone. A reset in the middle of a burst, after both flags are set, followed by a request in the very first cycle after reset, tests that reset clears everything.

// File: rtl/burst_responder_pkg.sv
package burst_responder_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BEAT = 2'd2,
    ST_DONE = 2'd3
  } rsp_state_e;
endpackage

// File: rtl/burst_lat_timer.sv
module burst_lat_timer #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CW = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(1);
    end else if (run) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign expire = run && (cnt_q == CW'(LATENCY - 1));
endmodule

// File: rtl/burst_beat_engine.sv
module burst_beat_engine #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int BEATS  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic              clear,
  input  logic [ADDR_W-1:0] seed,
  output logic [DATA_W-1:0] word,
  output logic              last
);
  localparam int STEP = DATA_W / 8;
  localparam int CW   = $clog2(BEATS + 1);

  logic [DATA_W-1:0] word_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] seed_w;

  generate
    if (ADDR_W >= DATA_W) begin : g_trunc
      assign seed_w = seed[DATA_W-1:0];
    end else begin : g_ext
      assign seed_w = {{(DATA_W-ADDR_W){1'b0}}, seed};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      word_q <= seed_w;
      cnt_q  <= CW'(1);
    end else if (adv) begin
      word_q <= word_q + DATA_W'(STEP);
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign word = word_q;
  assign last = (cnt_q == CW'(BEATS));
endmodule

// File: rtl/burst_err_flags.sv
module burst_err_flags #(
  parameter int AL_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 busy,
  input  logic [AL_W_OF-1:0]   addr_lo,
  output logic                 overlap,
  output logic                 misalign
);
  localparam int AL_W_OF = (AL_BITS < 1) ? 1 : AL_BITS;

  logic ovl_q;
  logic mis_q;
  logic odd_addr;

  generate
    if (AL_BITS == 0) begin : g_byte
      assign odd_addr = 1'b0 & addr_lo[0];
    end else begin : g_word
      assign odd_addr = |addr_lo;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_q <= 1'b0;
      mis_q <= 1'b0;
    end else begin
      if (req_valid && busy)             ovl_q <= 1'b1;
      if (req_valid && !busy && odd_addr) mis_q <= 1'b1;
    end
  end

  assign overlap  = ovl_q;
  assign misalign = mis_q;
endmodule

// File: rtl/burst_responder.sv
module burst_responder
  import burst_responder_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 2048,
  parameter int LATENCY     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_sync,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              err_overlap,
  output logic              err_misalign
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEATS      = BURST_BYTES / BEAT_BYTES;
  localparam int AL_BITS    = $clog2(BEAT_BYTES);
  localparam int AL_W       = (AL_BITS < 1) ? 1 : AL_BITS;
  localparam bit DIRECT     = (LATENCY == 1);

  rsp_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic              sync_q;
  logic              ready_q;
  logic [ADDR_W-1:0] echo_q;

  logic              accept;
  logic              lat_expire;
  logic              beat_last;
  logic              eng_load;
  logic              eng_adv;
  logic              eng_clear;
  logic [ADDR_W-1:0] eng_seed;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign eng_load  = (accept && DIRECT) || ((state_q == ST_WAIT) && lat_expire);
  assign eng_adv   = (state_q == ST_BEAT) && !beat_last;
  assign eng_clear = (state_q == ST_BEAT) && beat_last;
  assign eng_seed  = (state_q == ST_IDLE) ? req_addr : base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      sync_q  <= 1'b0;
      ready_q <= 1'b0;
      echo_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            base_q  <= req_addr;
            sync_q  <= DIRECT;
            state_q <= DIRECT ? ST_BEAT : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (lat_expire) begin
            sync_q  <= 1'b1;
            state_q <= ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (beat_last) begin
            sync_q  <= 1'b0;
            ready_q <= 1'b1;
            echo_q  <= base_q;
            state_q <= ST_DONE;
          end
        end
        default: begin
          ready_q <= 1'b0;
          echo_q  <= '0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  burst_lat_timer #(
    .LATENCY(LATENCY)
  ) u_lat (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .run   (state_q == ST_WAIT),
    .expire(lat_expire)
  );

  burst_beat_engine #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .BEATS (BEATS)
  ) u_beat (
    .clk  (clk),
    .rst  (rst),
    .load (eng_load),
    .adv  (eng_adv),
    .clear(eng_clear),
    .seed (eng_seed),
    .word (rsp_data),
    .last (beat_last)
  );

  burst_err_flags #(
    .AL_BITS(AL_BITS)
  ) u_err (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .busy     (state_q != ST_IDLE),
    .addr_lo  (req_addr[AL_W-1:0]),
    .overlap  (err_overlap),
    .misalign (err_misalign)
  );

  assign rsp_sync  = sync_q;
  assign rsp_ready = ready_q;
  assign rsp_addr  = echo_q;
endmodule

// File: rtl/burst_responder_chk.sv
module burst_responder_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rsp_sync,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              err_overlap,
  input logic              err_misalign
);
  localparam int STEP = DATA_W / 8;

  // R5
  ready_after_words_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> (!rsp_sync && $past(rsp_sync)));

  // R5
  ready_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |=> !rsp_ready);

  // R6
  echo_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_ready |-> (rsp_addr == '0));

  // R4
  data_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_sync && $past(rsp_sync)) |-> (rsp_data == $past(rsp_data) + DATA_W'(STEP)));

  // R4
  data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_sync |-> (rsp_data == '0));

  // R10
  overlap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_overlap |=> err_overlap);

  // R10
  misalign_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_misalign |=> err_misalign);
endmodule

bind burst_responder burst_responder_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rsp_sync    (rsp_sync),
  .rsp_data    (rsp_data),
  .rsp_ready   (rsp_ready),
  .rsp_addr    (rsp_addr),
  .err_overlap (err_overlap),
  .err_misalign(err_misalign)
);

// File: tb/burst_responder_bench.sv
`timescale 1ns/1ps
module burst_responder_bench;
  localparam int DW    = 32;
  localparam int AW    = 32;
  localparam int BB    = 32;
  localparam int LAT   = 3;
  localparam int BEATS = BB / (DW / 8);
  localparam int SPAN  = LAT + BEATS + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_sync;
  logic [DW-1:0] rsp_data;
  logic          rsp_ready;
  logic [AW-1:0] rsp_addr;
  logic          err_overlap;
  logic          err_misalign;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  exp_ov = 1'b0;
  bit  exp_mis = 1'b0;

  always #10 clk = ~clk;

  burst_responder #(
    .DATA_W(DW), .ADDR_W(AW), .BURST_BYTES(BB), .LATENCY(LAT)
  ) u_burst_responder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_sync(rsp_sync), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .err_overlap(err_overlap), .err_misalign(err_misalign)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_idle_outputs(input string tag);
    chk(tag, {31'd0, rsp_sync}, 32'd0);
    chk(tag, rsp_data, 32'd0);
    chk(tag, {31'd0, rsp_ready}, 32'd0);
    chk(tag, rsp_addr, 32'd0);
  endtask

  // One burst. If pre is set, the strobe was already driven for cycle c.
  // inj_k > 0 drives a stray strobe in cycle c+inj_k (R7).
  // chain drives the next request in the idle cycle after ready (R9).
  task automatic run_burst(input logic [31:0] addr, input bit pre, input int inj_k,
                           input bit chain, input logic [31:0] nxt);
    if (!pre) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = addr;
    end
    if ((addr[1:0] != 2'b00)) exp_mis = 1'b1;
    for (int k = 1; k <= SPAN; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      // outputs now show cycle c+k
      if (k < LAT) begin
        chk("R2 sync low in latency", {31'd0, rsp_sync}, 32'd0);
        chk("R4 data zero in latency", rsp_data, 32'd0);
      end else if (k < LAT + BEATS) begin
        chk("R3 sync high for word", {31'd0, rsp_sync}, 32'd1);
        chk("R4 word value", rsp_data, addr + 32'((k - LAT) * (DW / 8)));
        chk("R5 ready low during words", {31'd0, rsp_ready}, 32'd0);
        chk("R6 echo zero during words", rsp_addr, 32'd0);
      end else if (k == LAT + BEATS) begin
        chk("R5 ready pulse", {31'd0, rsp_ready}, 32'd1);
        chk("R5 sync low at ready", {31'd0, rsp_sync}, 32'd0);
        chk("R6 echoed address", rsp_addr, addr);
      end else begin
        chk("R5 ready single cycle", {31'd0, rsp_ready}, 32'd0);
        chk("R6 echo cleared", rsp_addr, 32'd0);
        chk("R3 no extra word", {31'd0, rsp_sync}, 32'd0);
      end
      if (k == inj_k) begin
        req_valid = 1'b1;
        req_addr  = ~addr;
        exp_ov    = 1'b1;
      end
      if (k == SPAN && chain) begin
        req_valid = 1'b1;
        req_addr  = nxt;
      end
    end
    chk("R7 overlap flag", {31'd0, err_overlap}, {31'd0, exp_ov});
    chk("R8 misalign flag", {31'd0, err_misalign}, {31'd0, exp_mis});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero while in reset
    check_idle_outputs("R1 outputs during reset");
    chk("R1 flags during reset", {30'd0, err_overlap, err_misalign}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    req_valid = 1'b1;
    req_addr = 32'h0000_1000;
    @(negedge clk);
    // R1: first cycle after reset shows zero outputs; request strobed there
    check_idle_outputs("R1 first cycle after reset");
    // strobe was in the cycle just checked; continue from there
    req_valid = 1'b0;
    for (int k = 2; k <= SPAN; k++) begin
      @(negedge clk);
      if (k == LAT) chk("R1 request after reset served", rsp_data, 32'h0000_1000);
      if (k == LAT + BEATS) chk("R1 echo after reset", rsp_addr, 32'h0000_1000);
    end

    // aligned sweep, isolated bursts
    for (int i = 0; i < 24; i++)
      run_burst(32'h0100_0000 * i + 32'h40 * i, 1'b0, 0, 1'b0, 32'd0);
    // data counter wraps past the top of the address space (R4)
    run_burst(32'hFFFF_FFF0, 1'b0, 0, 1'b0, 32'd0);

    // back-to-back chain (R9)
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 32'h2000_0000;
    for (int i = 0; i < 6; i++)
      run_burst(32'h2000_0000 + 32'h100 * i, 1'b1, 0, (i < 5), 32'h2000_0000 + 32'h100 * (i + 1));

    // misaligned sweep (R8)
    for (int i = 1; i < 16; i++)
      run_burst(32'h3000_0000 + i, 1'b0, 0, 1'b0, 32'd0);

    // stray strobes in wait, word and ready cycles (R7)
    run_burst(32'h4000_0000, 1'b0, 1, 1'b0, 32'd0);
    run_burst(32'h4000_1000, 1'b0, LAT + 2, 1'b0, 32'd0);
    run_burst(32'h4000_2000, 1'b0, LAT + BEATS, 1'b0, 32'd0);

    // R10: flags survive a clean burst
    run_burst(32'h5000_0000, 1'b0, 0, 1'b0, 32'd0);
    chk("R10 overlap held", {31'd0, err_overlap}, 32'd1);
    chk("R10 misalign held", {31'd0, err_misalign}, 32'd1);

    // reset in mid-burst clears all (R1, R10)
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 32'h6000_0000;
    repeat (LAT + 2) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
    rst = 1'b1;
    @(negedge clk);
    check_idle_outputs("R1 mid-burst reset");
    chk("R10 flags cleared by reset", {30'd0, err_overlap, err_misalign}, 32'd0);
    exp_ov  = 1'b0;
    exp_mis = 1'b0;
    rst = 1'b0;
    req_valid = 1'b1;
    req_addr = 32'h7000_0000;
    run_burst(32'h7000_0000, 1'b1, 0, 1'b0, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule